// File: doc/BRIEF.md
# Pulse-Width Command Decoder with Shunt Control

This block listens to a single command wire that shares its conductor with a supply bus. After the analog front end has squared up the AC-coupled signal, the block samples the resulting logic level with a fast clock. It measures the high time of every pulse and turns each pulse into a symbol: a short pulse reads as 0 and a long pulse reads as 1. Pulses that are too short are treated as noise. Pulses that are too long, or a line that stays quiet for too long, throw away any bits already collected, so the receiver falls back into step with the sender.

Five accepted symbols make one command. The first four form a node address, sent most significant bit first. The fifth is the command bit. Every node on the wire decodes every frame, but a node acts only when the address equals its strapped identity. When it acts, a command bit of 1 turns the local shunt on, which shorts the hybrid out of the series chain, and a command bit of 0 turns the shunt off. A separate overvoltage flag turns the shunt on at once, with no command needed. That forced state is remembered after the flag drops, until a reset or a release command that arrives while the flag is low.

Top module: `pwm_cmd_decoder`

## Requirements
- R1: While rst_ni is low and just after it is released, frame_valid_o is 0 and shunt_en_o is 0 when ovp_i is 0.
- R2: An accepted pulse whose high time in clk_i cycles is at least THRESH_CYC (default 20) decodes as 1. An accepted pulse shorter than that decodes as 0. A high time of GLITCH_CYC (5) is the shortest accepted pulse and ABORT_CYC (50) is the longest.
- R3: A pulse with a high time below GLITCH_CYC cycles is dropped: it adds no bit and does not disturb the frame in progress.
- R4: A pulse with a high time above ABORT_CYC cycles discards the partial frame and produces no bit.
- R5: A low time longer than IDLE_CYC cycles (default 100) discards the partial frame.
- R6: A frame is 4 address bits, most significant bit first, followed by 1 command bit. When the fifth bit is accepted, frame_valid_o is high for exactly one cycle, whether or not the address matches.
- R7: A frame whose address equals local_addr_i sets shunt_en_o to 1 when its command bit is 1, and clears the command state to 0 when its command bit is 0. The new state shows one cycle after frame_valid_o.
- R8: A frame whose address differs from local_addr_i leaves shunt_en_o unchanged.
- R9: While ovp_i is 1, shunt_en_o is 1 in the same cycle, whatever the command state.
- R10: Once ovp_i has been sampled high, shunt_en_o stays 1 after ovp_i falls. It returns to 0 only on reset, or on a matching command-bit-0 frame that is decoded while ovp_i is 0. Such a frame received while ovp_i is 1 does not release the shunt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, 5 ns nominal |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Digitized command line, asynchronous to clk_i |
| local_addr_i | input | 4 | Strapped node address |
| ovp_i | input | 1 | Overvoltage flag, high forces the shunt on |
| shunt_en_o | output | 1 | High shorts the local hybrid |
| frame_valid_o | output | 1 | One-cycle strobe for each complete frame |

## Verification
A bit counter that falls out of step shows up at the ports as a frame_valid_o strobe that is missing or extra. It also shows up as a shunt change caused by an address built from the wrong bits. Both appear within one frame of the fault. A wrong pulse classification, or a wrong shunt or latch state, shows on shunt_en_o one cycle after the frame strobe. The bench therefore compares the strobe count and shunt_en_o after every frame, and checks the overvoltage path in the same cycle ovp_i changes.

// File: rtl/pwm_cmd_pkg.sv
package pwm_cmd_pkg;

  typedef enum logic [1:0] {
    PW_NONE = 2'd0,
    PW_ZERO = 2'd1,
    PW_ONE  = 2'd2,
    PW_LONG = 2'd3
  } pw_class_e;

  function automatic pw_class_e classify_width(input int unsigned width,
                                               input int unsigned glitch_cyc,
                                               input int unsigned thresh_cyc,
                                               input int unsigned abort_cyc);
    if (width < glitch_cyc)      return PW_NONE;
    else if (width > abort_cyc)  return PW_LONG;
    else if (width >= thresh_cyc) return PW_ONE;
    else                         return PW_ZERO;
  endfunction

endpackage

// File: rtl/pwm_line_sync.sv
module pwm_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/pwm_pulse_meter.sv
module pwm_pulse_meter
  import pwm_cmd_pkg::*;
#(
  parameter int unsigned GLITCH_CYC = 5,
  parameter int unsigned THRESH_CYC = 20,
  parameter int unsigned ABORT_CYC  = 50,
  parameter int unsigned IDLE_CYC   = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic sym_valid_o,
  output logic sym_bit_o,
  output logic abort_o,
  output logic gap_o
);

  localparam int unsigned HI_MAX   = ABORT_CYC + 1;
  localparam int unsigned HI_W     = $clog2(HI_MAX + 1);
  localparam int unsigned IDLE_MAX = IDLE_CYC + 1;
  localparam int unsigned IDLE_W   = $clog2(IDLE_MAX + 1);

  logic [HI_W-1:0]   hi_cnt_q;
  logic [IDLE_W-1:0] idle_cnt_q;
  logic              fall;
  pw_class_e         cls;

  // high counter saturates above the abort limit so long pulses stay classified long
  always_comb begin
    cls  = classify_width(32'(hi_cnt_q), GLITCH_CYC, THRESH_CYC, ABORT_CYC);
    fall = !line_i && (hi_cnt_q != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q    <= '0;
      idle_cnt_q  <= '0;
      sym_valid_o <= 1'b0;
      sym_bit_o   <= 1'b0;
      abort_o     <= 1'b0;
      gap_o       <= 1'b0;
    end else begin
      sym_valid_o <= 1'b0;
      abort_o     <= 1'b0;
      gap_o       <= 1'b0;
      if (line_i) begin
        idle_cnt_q <= '0;
        if (hi_cnt_q != HI_W'(HI_MAX)) hi_cnt_q <= hi_cnt_q + HI_W'(1);
      end else begin
        hi_cnt_q <= '0;
        if (fall) begin
          unique case (cls)
            PW_ZERO: begin
              sym_valid_o <= 1'b1;
              sym_bit_o   <= 1'b0;
            end
            PW_ONE: begin
              sym_valid_o <= 1'b1;
              sym_bit_o   <= 1'b1;
            end
            PW_LONG: abort_o <= 1'b1;
            default: ;
          endcase
        end
        if (idle_cnt_q != IDLE_W'(IDLE_MAX)) idle_cnt_q <= idle_cnt_q + IDLE_W'(1);
        if (idle_cnt_q == IDLE_W'(IDLE_CYC)) gap_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_frame_collect.sv
module pwm_frame_collect #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_valid_i,
  input  logic              sym_bit_i,
  input  logic              flush_i,
  output logic              frame_valid_o,
  output logic [ADDR_W-1:0] frame_addr_o,
  output logic              frame_data_o
);

  localparam int unsigned CNT_W = $clog2(ADDR_W + 1);

  logic [CNT_W-1:0]  bit_cnt_q;
  logic [ADDR_W-1:0] addr_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q     <= '0;
      addr_sr_q     <= '0;
      frame_valid_o <= 1'b0;
      frame_addr_o  <= '0;
      frame_data_o  <= 1'b0;
    end else begin
      frame_valid_o <= 1'b0;
      if (flush_i) begin
        bit_cnt_q <= '0;
      end else if (sym_valid_i) begin
        if (bit_cnt_q == CNT_W'(ADDR_W)) begin
          frame_valid_o <= 1'b1;
          frame_addr_o  <= addr_sr_q;
          frame_data_o  <= sym_bit_i;
          bit_cnt_q     <= '0;
        end else begin
          addr_sr_q <= {addr_sr_q[ADDR_W-2:0], sym_bit_i};  // msb first
          bit_cnt_q <= bit_cnt_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pwm_shunt_ctrl.sv
module pwm_shunt_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic cmd_data_i,
  input  logic ovp_i,
  output logic shunt_en_o
);

  logic cmd_short_q;
  logic ovp_latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_short_q <= 1'b0;
      ovp_latch_q <= 1'b0;
    end else begin
      if (ovp_i)                           ovp_latch_q <= 1'b1;
      else if (cmd_valid_i && !cmd_data_i) ovp_latch_q <= 1'b0;
      if (cmd_valid_i) cmd_short_q <= cmd_data_i;
    end
  end

  // ovp path bypasses all registers
  assign shunt_en_o = ovp_i | ovp_latch_q | cmd_short_q;

endmodule

// File: rtl/pwm_cmd_decoder.sv
module pwm_cmd_decoder #(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GLITCH_CYC  = 5,
  parameter int unsigned THRESH_CYC  = 20,
  parameter int unsigned ABORT_CYC   = 50,
  parameter int unsigned IDLE_CYC    = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic [ADDR_W-1:0] local_addr_i,
  input  logic              ovp_i,
  output logic              shunt_en_o,
  output logic              frame_valid_o
);

  logic              line_s;
  logic              sym_valid, sym_bit, sym_abort, line_gap;
  logic [ADDR_W-1:0] frame_addr;
  logic              frame_data;
  logic              cmd_hit;

  pwm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  pwm_pulse_meter #(
    .GLITCH_CYC(GLITCH_CYC),
    .THRESH_CYC(THRESH_CYC),
    .ABORT_CYC (ABORT_CYC),
    .IDLE_CYC  (IDLE_CYC)
  ) u_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_s),
    .sym_valid_o(sym_valid),
    .sym_bit_o  (sym_bit),
    .abort_o    (sym_abort),
    .gap_o      (line_gap)
  );

  pwm_frame_collect #(.ADDR_W(ADDR_W)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sym_valid_i  (sym_valid),
    .sym_bit_i    (sym_bit),
    .flush_i      (sym_abort | line_gap),
    .frame_valid_o(frame_valid_o),
    .frame_addr_o (frame_addr),
    .frame_data_o (frame_data)
  );

  assign cmd_hit = frame_valid_o && (frame_addr == local_addr_i);

  pwm_shunt_ctrl u_shunt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_hit),
    .cmd_data_i (frame_data),
    .ovp_i      (ovp_i),
    .shunt_en_o (shunt_en_o)
  );

endmodule

// File: rtl/pwm_cmd_decoder_chk.sv
module pwm_cmd_decoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ovp_i,
  input logic shunt_en_o,
  input logic frame_valid_o
);

  always_comb begin
    if (!rst_ni) begin
      p_quiet_reset_r1: assert (frame_valid_o == 1'b0);
    end
  end

  p_single_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);

  p_ovp_force_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovp_i |-> shunt_en_o);

  p_ovp_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovp_i) |-> shunt_en_o);

  p_set_by_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(shunt_en_o) && !ovp_i) |-> $past(frame_valid_o));

  p_release_by_frame_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shunt_en_o) |-> ($past(frame_valid_o) && !ovp_i));

endmodule

bind pwm_cmd_decoder pwm_cmd_decoder_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ovp_i        (ovp_i),
  .shunt_en_o   (shunt_en_o),
  .frame_valid_o(frame_valid_o)
);

// File: tb/pwm_cmd_decoder_tb.sv
`timescale 1ns/1ps
module pwm_cmd_decoder_tb;

  localparam logic [3:0] LOCAL = 4'hA;
  localparam int GAP = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic ovp = 1'b0;
  logic shunt_en, frame_valid;

  int n_chk = 0, n_bad = 0;
  int fv_cnt = 0, fv_wide = 0, exp_fv = 0;
  logic fv_prev = 1'b0;
  bit exp_short = 1'b0, exp_latch = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_cmd_decoder u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .line_i       (line),
    .local_addr_i (LOCAL),
    .ovp_i        (ovp),
    .shunt_en_o   (shunt_en),
    .frame_valid_o(frame_valid)
  );

  always @(negedge clk) begin
    if (frame_valid) fv_cnt++;
    if (frame_valid && fv_prev) fv_wide++;
    fv_prev = frame_valid;
  end

  function automatic bit exp_shunt();
    return ovp | exp_latch | exp_short;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic pulse(input int n, input int gap);
    line = 1'b1;
    repeat (n) @(negedge clk);
    line = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    pulse(b ? int'($urandom_range(46, 22)) : int'($urandom_range(18, 6)), GAP);
  endtask

  task automatic model_frame(input logic [3:0] addr, input bit data);
    exp_fv++;
    if (addr == LOCAL) begin
      exp_short = data;
      if (!data && !ovp) exp_latch = 1'b0;
    end
  endtask

  task automatic send_frame(input logic [3:0] addr, input bit data);
    for (int i = 3; i >= 0; i--) send_bit(addr[i]);
    send_bit(data);
    repeat (120) @(negedge clk);
    model_frame(addr, data);
  endtask

  task automatic set_ovp(input bit v);
    ovp = v;
    if (v) exp_latch = 1'b1;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    check("R1 frame_valid in reset", frame_valid, 0);
    check("R1 shunt in reset", shunt_en, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 shunt after reset", shunt_en, 0);

    // R7 basic set and release
    send_frame(LOCAL, 1'b1);
    check("R7 set", shunt_en, exp_shunt());
    send_frame(LOCAL, 1'b0);
    check("R7 release", shunt_en, exp_shunt());

    // R8 foreign address
    send_frame(4'h3, 1'b1);
    check("R8 foreign", shunt_en, 0);
    check("R6 strobe on foreign frame", fv_cnt, exp_fv);

    // R6 bit order: reversed local address must not match
    send_frame(4'h5, 1'b1);
    check("R6 msb first", shunt_en, 0);

    // R2 threshold edges: 20 and 50 are ones, 19 and 5 are zeros
    pulse(20, GAP); pulse(19, GAP); pulse(50, GAP); pulse(5, GAP);
    pulse(20, GAP); repeat (120) @(negedge clk);
    model_frame(LOCAL, 1'b1);
    check("R2 threshold decode set", shunt_en, 1);
    pulse(50, GAP); pulse(5, GAP); pulse(20, GAP); pulse(19, GAP);
    pulse(19, GAP); repeat (120) @(negedge clk);
    model_frame(LOCAL, 1'b0);
    check("R2 threshold decode release", shunt_en, 0);

    // R3 glitch inside a frame
    send_bit(1); send_bit(0);
    pulse(3, GAP);
    pulse(4, GAP);
    send_bit(1); send_bit(0); send_bit(1);
    repeat (120) @(negedge clk);
    model_frame(LOCAL, 1'b1);
    check("R3 glitch ignored shunt", shunt_en, 1);
    check("R3 glitch ignored count", fv_cnt, exp_fv);
    send_frame(LOCAL, 1'b0);

    // R4 over-long pulse aborts
    send_bit(1); send_bit(0);
    pulse(51, GAP);
    send_frame(LOCAL, 1'b1);
    check("R4 abort count", fv_cnt, exp_fv);
    check("R4 abort shunt", shunt_en, 1);
    send_frame(LOCAL, 1'b0);

    // R5 idle gap resync
    send_bit(1); send_bit(0); send_bit(1);
    repeat (130) @(negedge clk);
    send_frame(LOCAL, 1'b1);
    check("R5 gap count", fv_cnt, exp_fv);
    check("R5 gap shunt", shunt_en, 1);
    send_frame(LOCAL, 1'b0);
    check("R5 released", shunt_en, 0);

    // R9 and R10 overvoltage
    set_ovp(1'b1);
    check("R9 immediate force", shunt_en, 1);
    send_frame(LOCAL, 1'b0);
    check("R9 command overridden", shunt_en, 1);
    @(negedge clk);
    set_ovp(1'b0);
    check("R10 release under ovp ignored", shunt_en, 1);
    repeat (10) @(negedge clk);
    check("R10 latched", shunt_en, 1);
    send_frame(4'h3, 1'b0);
    check("R10 foreign release ignored", shunt_en, 1);
    send_frame(LOCAL, 1'b0);
    check("R10 release after clear", shunt_en, 0);
    @(negedge clk);
    set_ovp(1'b1);
    @(negedge clk);
    set_ovp(1'b0);
    repeat (3) @(negedge clk);
    check("R10 short ovp latched", shunt_en, 1);
    rst_n = 1'b0;
    exp_latch = 1'b0;
    exp_short = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset clears", shunt_en, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [3:0] a;
      bit d;
      if ($urandom_range(9, 0) == 0) begin
        set_ovp(~ovp);
        check("R9 ovp toggle", shunt_en, exp_shunt());
      end
      a = ($urandom_range(1, 0) == 1) ? LOCAL : 4'($urandom_range(15, 0));
      d = 1'($urandom_range(1, 0));
      send_frame(a, d);
      check(a == LOCAL ? "R7 random frame" : "R8 random frame", shunt_en, exp_shunt());
    end
    set_ovp(1'b0);

    check("R6 total strobes", fv_cnt, exp_fv);
    check("R6 strobe width", fv_wide, 0);
    finish_run();
  end

endmodule